// File: doc/BRIEF.md
# Store and Load Access Gatekeeper

This block sits between a core's load/store unit and two memory-side targets: a device (MMIO) window and a physical memory window. Each request carries an address, a size code, write data, an optional tag word and three ordering flags (acquire, release, conditional). The block screens the request for alignment and unsupported flag mixes, applies an externally evaluated protection verdict, decodes the address against a parameterised map, and then either forwards the access to the chosen target over a valid/ready handshake or answers at once with an exception cause.

Stores carry a write-kind code derived from their ordering flags, and every write carries a tag: the caller's tag when it supplies one, a fixed default tag otherwise. One request is in flight at a time; `req_ready` is high only while the block is idle, and every accepted request produces exactly one single-cycle response.

Top module: `memchk_dispatch`

## Requirements
- R1: A store with release or conditional set whose address is not a multiple of the access width (1, 2, 4 or 8 bytes, from size code 0..3) responds with `resp_exc`=1 and cause 6. This check beats every other check. No target is accessed, and the response comes in the cycle after acceptance. Stores without release and conditional set, and all loads, are never faulted for alignment.
- R2: For a forwarded store, `mem_kind` encodes the flags {aq,rl,con}. 000 gives 0 (plain). 010 gives 1 (release). 001 gives 2 (conditional). 011 gives 3 (conditional-release). 110 gives 4 (strong-release). 111 gives 5 (conditional-strong-release).
- R3: A store with aq=1 and rl=0 that passed R1 responds with `resp_unimpl`=1 and `resp_exc`=0, and no target is accessed.
- R4: With `prot_en`=1 and `prot_allow`=0, a request that passed R1 and R3 faults with cause 5 for a load or 7 for a store, and no target is accessed. With `prot_allow`=1 it proceeds to decode.
- R5: With `prot_en`=0, `prot_allow` has no effect and the request proceeds to decode.
- R6: The device window is tested before physical memory. Loads use the readable device window and stores use the writable one. A load that falls only in the writable window is not a device access.
- R7: A window matches only if every byte from the address to the address plus width minus 1 lies inside it.
- R8: A request that matches no window faults with cause 5 for a load and 7 for a store.
- R9: With `req_meta_en`=1, `mem_meta` carries `req_meta`. With `req_meta_en`=0, it carries the default tag, 4'h5 by default.
- R10: Stores with ordering flags set, including conditional ones, are forwarded to the device target like any other store when they fall in the writable window.
- R11: A target's valid, address and data stay stable until its ready is seen. The response follows one cycle after that handshake and carries the target's read data for loads. `req_ready` is low from acceptance until the response cycle, and `resp_valid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | log2 of access width in bytes |
| req_wdata | input | DATA_W | Store data |
| req_meta | input | META_W | Caller tag |
| req_meta_en | input | 1 | Use caller tag instead of default |
| req_aq | input | 1 | Acquire flag |
| req_rl | input | 1 | Release flag |
| req_con | input | 1 | Conditional flag |
| prot_en | input | 1 | Protection checking enabled |
| prot_allow | input | 1 | External protection verdict (1 = permit) |
| mmio_valid | output | 1 | Device target request |
| mmio_ready | input | 1 | Device target accepts |
| mmio_rdata | input | DATA_W | Device read data |
| phys_valid | output | 1 | Memory target request |
| phys_ready | input | 1 | Memory target accepts |
| phys_rdata | input | DATA_W | Memory read data |
| mem_we | output | 1 | Forwarded access is a write |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_size | output | 2 | Forwarded size code |
| mem_wdata | output | DATA_W | Forwarded write data |
| mem_meta | output | META_W | Forwarded tag |
| mem_kind | output | 3 | Write-kind code |
| resp_valid | output | 1 | Response pulse |
| resp_exc | output | 1 | Response is an exception |
| resp_cause | output | 4 | Exception cause |
| resp_unimpl | output | 1 | Unsupported flag combination |
| resp_rdata | output | DATA_W | Load result |

## Verification
A wrong decode latched at acceptance shows on the very next cycle. Either a target strobe rises where an immediate fault was due, or the response pulse carries the wrong cause or unsupported flag. The bench therefore watches for both and records every target handshake. A corrupted write-kind or tag register shows only on the forwarded write, so the bench captures `mem_kind` and `mem_meta` at the handshake edge for every flag mix. A state machine stuck in its busy state shows as a missing response and a `req_ready` that stays low. This is caught within the bounded wait of each scenario.

// File: rtl/memchk_pkg.sv
package memchk_pkg;
  typedef enum logic [2:0] {
    WK_PLAIN           = 3'd0,
    WK_REL             = 3'd1,
    WK_COND            = 3'd2,
    WK_COND_REL        = 3'd3,
    WK_STRONG_REL      = 3'd4,
    WK_COND_STRONG_REL = 3'd5
  } wkind_e;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_RESP} state_e;

  localparam logic [3:0] CAUSE_LD_ACCESS   = 4'd5;
  localparam logic [3:0] CAUSE_ST_MISALIGN = 4'd6;
  localparam logic [3:0] CAUSE_ST_ACCESS   = 4'd7;
endpackage

// File: rtl/memchk_precheck.sv
module memchk_precheck
  import memchk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              is_store,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              aq,
  input  logic              rl,
  input  logic              con,
  output logic              misalign,
  output logic              unimpl,
  output wkind_e            kind
);
  logic off_grid;

  always_comb begin
    case (size)
      2'd0:    off_grid = 1'b0;
      2'd1:    off_grid = addr[0];
      2'd2:    off_grid = |addr[1:0];
      default: off_grid = |addr[2:0];
    endcase
  end

  // only ordered or conditional stores demand natural alignment
  assign misalign = is_store && (rl || con) && off_grid;
  assign unimpl   = is_store && aq && !rl;

  always_comb begin
    case ({aq, rl, con})
      3'b010:  kind = WK_REL;
      3'b001:  kind = WK_COND;
      3'b011:  kind = WK_COND_REL;
      3'b110:  kind = WK_STRONG_REL;
      3'b111:  kind = WK_COND_STRONG_REL;
      default: kind = WK_PLAIN;
    endcase
  end
endmodule

// File: rtl/memchk_region.sv
module memchk_region #(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = '0,
  parameter logic [ADDR_W:0]   SPAN   = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              hit
);
  typedef logic [ADDR_W:0] wide_t;
  localparam wide_t TOP = {1'b0, BASE} + SPAN - wide_t'(1);

  wide_t last_byte;

  // one extra bit keeps an access that wraps past the top of the space out
  assign last_byte = {1'b0, addr} + (wide_t'(1) << size) - wide_t'(1);
  assign hit = (addr >= BASE) && (last_byte <= TOP);
endmodule

// File: rtl/memchk_dispatch.sv
module memchk_dispatch
  import memchk_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                DATA_W       = 64,
  parameter int                META_W       = 4,
  parameter logic [META_W-1:0] DEFAULT_META = 4'h5,
  parameter logic [ADDR_W-1:0] MMIO_RD_BASE = 32'h1000_0000,
  parameter logic [ADDR_W:0]   MMIO_RD_SPAN = 33'h0_0000_2000,
  parameter logic [ADDR_W-1:0] MMIO_WR_BASE = 32'h1000_1000,
  parameter logic [ADDR_W:0]   MMIO_WR_SPAN = 33'h0_0000_2000,
  parameter logic [ADDR_W-1:0] PHYS_BASE    = 32'h8000_0000,
  parameter logic [ADDR_W:0]   PHYS_SPAN    = 33'h0_0001_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [META_W-1:0] req_meta,
  input  logic              req_meta_en,
  input  logic              req_aq,
  input  logic              req_rl,
  input  logic              req_con,
  input  logic              prot_en,
  input  logic              prot_allow,
  output logic              mmio_valid,
  input  logic              mmio_ready,
  input  logic [DATA_W-1:0] mmio_rdata,
  output logic              phys_valid,
  input  logic              phys_ready,
  input  logic [DATA_W-1:0] phys_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [META_W-1:0] mem_meta,
  output logic [2:0]        mem_kind,
  output logic              resp_valid,
  output logic              resp_exc,
  output logic [3:0]        resp_cause,
  output logic              resp_unimpl,
  output logic [DATA_W-1:0] resp_rdata
);
  state_e state;
  logic   accept;
  logic   pre_misalign, pre_unimpl;
  wkind_e pre_kind;
  logic   hit_mrd, hit_mwr, hit_phys, in_mmio;
  logic   dec_err, dec_unimpl, dec_mmio, dec_phys;
  logic [3:0] dec_cause, fault_cause;
  logic   handshake;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  memchk_precheck #(.ADDR_W(ADDR_W)) u_pre (
    .is_store(req_store), .addr(req_addr), .size(req_size),
    .aq(req_aq), .rl(req_rl), .con(req_con),
    .misalign(pre_misalign), .unimpl(pre_unimpl), .kind(pre_kind)
  );

  memchk_region #(.ADDR_W(ADDR_W), .BASE(MMIO_RD_BASE), .SPAN(MMIO_RD_SPAN)) u_mrd (
    .addr(req_addr), .size(req_size), .hit(hit_mrd)
  );
  memchk_region #(.ADDR_W(ADDR_W), .BASE(MMIO_WR_BASE), .SPAN(MMIO_WR_SPAN)) u_mwr (
    .addr(req_addr), .size(req_size), .hit(hit_mwr)
  );
  memchk_region #(.ADDR_W(ADDR_W), .BASE(PHYS_BASE), .SPAN(PHYS_SPAN)) u_phys (
    .addr(req_addr), .size(req_size), .hit(hit_phys)
  );

  assign in_mmio     = req_store ? hit_mwr : hit_mrd;
  assign fault_cause = req_store ? CAUSE_ST_ACCESS : CAUSE_LD_ACCESS;

  // priority: alignment, unsupported flags, protection, device, memory, fault
  always_comb begin
    dec_err    = 1'b0;
    dec_unimpl = 1'b0;
    dec_mmio   = 1'b0;
    dec_phys   = 1'b0;
    dec_cause  = '0;
    if (pre_misalign) begin
      dec_err   = 1'b1;
      dec_cause = CAUSE_ST_MISALIGN;
    end else if (pre_unimpl) begin
      dec_unimpl = 1'b1;
    end else if (prot_en && !prot_allow) begin
      dec_err   = 1'b1;
      dec_cause = fault_cause;
    end else if (in_mmio) begin
      dec_mmio = 1'b1;
    end else if (hit_phys) begin
      dec_phys = 1'b1;
    end else begin
      dec_err   = 1'b1;
      dec_cause = fault_cause;
    end
  end

  assign handshake = (mmio_valid && mmio_ready) || (phys_valid && phys_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      mmio_valid  <= 1'b0;
      phys_valid  <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_size    <= '0;
      mem_wdata   <= '0;
      mem_meta    <= '0;
      mem_kind    <= '0;
      resp_valid  <= 1'b0;
      resp_exc    <= 1'b0;
      resp_cause  <= '0;
      resp_unimpl <= 1'b0;
      resp_rdata  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          mem_we    <= req_store;
          mem_addr  <= req_addr;
          mem_size  <= req_size;
          mem_wdata <= req_wdata;
          mem_meta  <= req_meta_en ? req_meta : DEFAULT_META;
          mem_kind  <= req_store ? pre_kind : WK_PLAIN;
          if (dec_mmio || dec_phys) begin
            mmio_valid <= dec_mmio;
            phys_valid <= dec_phys;
            state      <= ST_BUSY;
          end else begin
            resp_valid  <= 1'b1;
            resp_exc    <= dec_err;
            resp_cause  <= dec_cause;
            resp_unimpl <= dec_unimpl;
            resp_rdata  <= '0;
            state       <= ST_RESP;
          end
        end
        ST_BUSY: if (handshake) begin
          mmio_valid  <= 1'b0;
          phys_valid  <= 1'b0;
          resp_valid  <= 1'b1;
          resp_exc    <= 1'b0;
          resp_cause  <= '0;
          resp_unimpl <= 1'b0;
          resp_rdata  <= mem_we ? '0 : (mmio_valid ? mmio_rdata : phys_rdata);
          state       <= ST_RESP;
        end
        default: begin
          resp_valid <= 1'b0;
          state      <= ST_IDLE;
        end
      endcase
    end
  end

  // R1
  misalign_first_chk: assert property (@(posedge clk) disable iff (rst)
    accept && pre_misalign |=> resp_valid && resp_exc && resp_cause == 4'd6
                               && !mmio_valid && !phys_valid);

  // R3
  unimpl_noaccess_chk: assert property (@(posedge clk) disable iff (rst)
    accept && pre_unimpl && !pre_misalign |=> resp_valid && resp_unimpl && !resp_exc
                                              && !mmio_valid && !phys_valid);

  // R4
  prot_deny_chk: assert property (@(posedge clk) disable iff (rst)
    accept && prot_en && !prot_allow && !pre_misalign && !pre_unimpl
      |=> resp_valid && resp_exc && !mmio_valid && !phys_valid);

  // R11
  mmio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mmio_valid && !mmio_ready |=> mmio_valid && $stable(mem_addr) && $stable(mem_wdata));

  // R11
  phys_hold_chk: assert property (@(posedge clk) disable iff (rst)
    phys_valid && !phys_ready |=> phys_valid && $stable(mem_addr) && $stable(mem_wdata));

  // R11
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  // R11
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mmio_valid, phys_valid, resp_valid}));

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (mmio_valid || phys_valid) |-> !req_ready);
endmodule

// File: tb/memchk_dispatch_bench.sv
`timescale 1ns/1ps
module memchk_dispatch_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_ready;
  logic        req_store = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic [3:0]  req_meta = '0;
  logic        req_meta_en = 1'b0;
  logic        req_aq = 1'b0, req_rl = 1'b0, req_con = 1'b0;
  logic        prot_en = 1'b0, prot_allow = 1'b0;
  logic        mmio_valid, phys_valid;
  logic        mmio_ready = 1'b1, phys_ready = 1'b1;
  logic [63:0] mmio_rdata, phys_rdata;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [63:0] mem_wdata;
  logic [3:0]  mem_meta;
  logic [2:0]  mem_kind;
  logic        resp_valid, resp_exc, resp_unimpl;
  logic [3:0]  resp_cause;
  logic [63:0] resp_rdata;

  always #2.5 clk = ~clk;

  assign mmio_rdata = {~mem_addr, mem_addr};
  assign phys_rdata = {mem_addr, ~mem_addr};

  memchk_dispatch u_memchk_dispatch (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_store(req_store), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .req_meta(req_meta), .req_meta_en(req_meta_en),
    .req_aq(req_aq), .req_rl(req_rl), .req_con(req_con),
    .prot_en(prot_en), .prot_allow(prot_allow),
    .mmio_valid(mmio_valid), .mmio_ready(mmio_ready), .mmio_rdata(mmio_rdata),
    .phys_valid(phys_valid), .phys_ready(phys_ready), .phys_rdata(phys_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_meta(mem_meta), .mem_kind(mem_kind),
    .resp_valid(resp_valid), .resp_exc(resp_exc), .resp_cause(resp_cause),
    .resp_unimpl(resp_unimpl), .resp_rdata(resp_rdata)
  );

  int checks = 0;
  int errors = 0;

  // handshake monitor: 1 = device, 2 = memory
  int          acc_cnt = 0;
  int          last_tgt = 0;
  logic        last_we;
  logic [31:0] last_addr;
  logic [63:0] last_wdata;
  logic [3:0]  last_meta;
  logic [2:0]  last_kind;

  always @(posedge clk) begin
    if (!rst && ((mmio_valid && mmio_ready) || (phys_valid && phys_ready))) begin
      acc_cnt    <= acc_cnt + 1;
      last_tgt   <= mmio_valid ? 1 : 2;
      last_we    <= mem_we;
      last_addr  <= mem_addr;
      last_wdata <= mem_wdata;
      last_meta  <= mem_meta;
      last_kind  <= mem_kind;
    end
  end

  logic        r_exc, r_unimpl;
  logic [3:0]  r_cause;
  logic [63:0] r_rdata;
  int          r_lat, r_acc;
  int          stall_cycles = 0;
  logic        busy_ready_seen;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_req(input logic st, input logic [31:0] a, input logic [1:0] sz,
                        input logic [63:0] wd, input logic [3:0] mt, input logic mten,
                        input logic aq, input logic rl, input logic con,
                        input logic pen, input logic pallow);
    int start_acc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_store = st; req_addr = a; req_size = sz; req_wdata = wd;
    req_meta = mt; req_meta_en = mten; req_aq = aq; req_rl = rl; req_con = con;
    prot_en = pen; prot_allow = pallow;
    if (stall_cycles > 0) begin
      mmio_ready = 1'b0;
      phys_ready = 1'b0;
    end
    start_acc = acc_cnt;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 0;
    busy_ready_seen = 1'b0;
    while (!resp_valid && r_lat < 50) begin
      if (r_lat >= stall_cycles) begin
        mmio_ready = 1'b1;
        phys_ready = 1'b1;
      end
      if (req_ready) busy_ready_seen = 1'b1;
      r_lat++;
      @(negedge clk);
    end
    r_exc = resp_exc; r_cause = resp_cause; r_unimpl = resp_unimpl; r_rdata = resp_rdata;
    r_acc = acc_cnt - start_acc;
    mmio_ready = 1'b1;
    phys_ready = 1'b1;
    if (r_lat >= 50) chk("R11", "response timeout", 64'(r_lat), 64'd0);
  endtask

  task automatic t_reset;
    chk("R11", "reset req_ready", 64'(req_ready), 64'd1);
    chk("R11", "reset resp_valid", 64'(resp_valid), 64'd0);
    chk("R11", "reset mmio_valid", 64'(mmio_valid), 64'd0);
    chk("R11", "reset phys_valid", 64'(phys_valid), 64'd0);
  endtask

  task automatic t_load_phys;
    do_req(1'b0, 32'h8000_0010, 2'd3, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R11", "load phys exc", 64'(r_exc), 64'd0);
    chk("R11", "load phys rdata", r_rdata, {32'h8000_0010, ~32'h8000_0010});
    chk("R6", "load phys target", 64'(last_tgt), 64'd2);
    chk("R11", "load phys latency", 64'(r_lat), 64'd1);
    // loads are never faulted for alignment
    do_req(1'b0, 32'h8000_0013, 2'd2, '0, '0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R1", "misaligned load forwarded", 64'(r_acc), 64'd1);
  endtask

  task automatic t_kinds;
    logic [2:0] flags [6] = '{3'b000, 3'b010, 3'b001, 3'b011, 3'b110, 3'b111};
    logic [2:0] codes [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5};
    for (int i = 0; i < 6; i++) begin
      do_req(1'b1, 32'h8000_0100, 2'd2, 64'(i) + 64'hBEEF, '0, 1'b0,
             flags[i][2], flags[i][1], flags[i][0], 1'b0, 1'b0);
      chk("R2", $sformatf("kind for flags %b", flags[i]), 64'(last_kind), 64'(codes[i]));
      chk("R2", "write data", last_wdata, 64'(i) + 64'hBEEF);
    end
  endtask

  task automatic t_misalign;
    do_req(1'b1, 32'h8000_0102, 2'd2, '0, '0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1", "release misaligned cause", 64'(r_cause), 64'd6);
    chk("R1", "release misaligned exc", 64'(r_exc), 64'd1);
    chk("R1", "release misaligned no access", 64'(r_acc), 64'd0);
    chk("R1", "error latency", 64'(r_lat), 64'd0);
    // beats unsupported-flag check
    do_req(1'b1, 32'h8000_0101, 2'd1, '0, '0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R1", "misalign over unimpl cause", 64'(r_cause), 64'd6);
    chk("R1", "misalign over unimpl flag", 64'(r_unimpl), 64'd0);
    // beats protection and region faults
    do_req(1'b1, 32'h0000_0004, 2'd3, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R1", "misalign over prot/region", 64'(r_cause), 64'd6);
    // plain misaligned store is forwarded
    do_req(1'b1, 32'h8000_0203, 2'd2, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1", "plain misaligned forwarded", 64'(r_acc), 64'd1);
  endtask

  task automatic t_unimpl;
    do_req(1'b1, 32'h8000_0300, 2'd3, '0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3", "aq-only unimpl", 64'(r_unimpl), 64'd1);
    chk("R3", "aq-only exc", 64'(r_exc), 64'd0);
    chk("R3", "aq-only no access", 64'(r_acc), 64'd0);
    do_req(1'b1, 32'h8000_0300, 2'd3, '0, '0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R3", "aq+con unimpl", 64'(r_unimpl), 64'd1);
    chk("R3", "aq+con no access", 64'(r_acc), 64'd0);
  endtask

  task automatic t_prot;
    do_req(1'b0, 32'h8000_0400, 2'd2, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4", "deny load cause", 64'(r_cause), 64'd5);
    chk("R4", "deny load no access", 64'(r_acc), 64'd0);
    do_req(1'b1, 32'h1000_1800, 2'd2, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4", "deny store cause", 64'(r_cause), 64'd7);
    chk("R4", "deny store no access", 64'(r_acc), 64'd0);
    do_req(1'b1, 32'h8000_0400, 2'd2, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R4", "permit store forwarded", 64'(r_acc), 64'd1);
    chk("R4", "permit store exc", 64'(r_exc), 64'd0);
    do_req(1'b0, 32'h8000_0400, 2'd2, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5", "disabled ignores deny", 64'(r_acc), 64'd1);
    chk("R5", "disabled no exc", 64'(r_exc), 64'd0);
  endtask

  task automatic t_regions;
    do_req(1'b0, 32'h1000_0000, 2'd3, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6", "readable device load target", 64'(last_tgt), 64'd1);
    chk("R6", "device load rdata", r_rdata, {~32'h1000_0000, 32'h1000_0000});
    do_req(1'b1, 32'h1000_2800, 2'd2, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6", "writable device store target", 64'(last_tgt), 64'd1);
    chk("R6", "device store we", 64'(last_we), 64'd1);
    do_req(1'b0, 32'h1000_2800, 2'd2, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R6", "load in write-only window", 64'(r_cause), 64'd5);
    chk("R6", "load in write-only no access", 64'(r_acc), 64'd0);
    do_req(1'b1, 32'h1000_0400, 2'd2, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8", "store in read-only window", 64'(r_cause), 64'd7);
    do_req(1'b0, 32'h8000_FFFC, 2'd3, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7", "straddling load faults", 64'(r_cause), 64'd5);
    chk("R7", "straddling load no access", 64'(r_acc), 64'd0);
    do_req(1'b0, 32'h8000_FFF8, 2'd3, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R7", "last dword load ok", 64'(r_exc), 64'd0);
    do_req(1'b1, 32'h0000_0000, 2'd0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8", "unmapped store cause", 64'(r_cause), 64'd7);
    do_req(1'b0, 32'hFFFF_FFFC, 2'd3, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8", "unmapped wrapping load cause", 64'(r_cause), 64'd5);
  endtask

  task automatic t_meta;
    do_req(1'b1, 32'h8000_0500, 2'd3, 64'h1, 4'h3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9", "default tag", 64'(last_meta), 64'h5);
    do_req(1'b1, 32'h8000_0508, 2'd3, 64'h2, 4'hC, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R9", "caller tag", 64'(last_meta), 64'hC);
  endtask

  task automatic t_mmio_atomic;
    do_req(1'b1, 32'h1000_1800, 2'd3, 64'h77, '0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R10", "cond strong store to device", 64'(last_tgt), 64'd1);
    chk("R10", "cond strong kind", 64'(last_kind), 64'd5);
    chk("R10", "no exception", 64'(r_exc), 64'd0);
  endtask

  task automatic t_stall;
    stall_cycles = 3;
    do_req(1'b0, 32'h1000_0040, 2'd2, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R11", "stalled latency", 64'(r_lat), 64'd4);
    chk("R11", "req_ready low while busy", 64'(busy_ready_seen), 64'd0);
    chk("R11", "stalled rdata", r_rdata, {~32'h1000_0040, 32'h1000_0040});
    chk("R11", "single handshake", 64'(r_acc), 64'd1);
    stall_cycles = 2;
    do_req(1'b1, 32'h8000_0600, 2'd3, 64'hCAFE, '0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R11", "stalled store latency", 64'(r_lat), 64'd3);
    chk("R11", "stalled store addr", 64'(last_addr), 64'h8000_0600);
    stall_cycles = 0;
    @(negedge clk);
    chk("R11", "resp pulse one cycle", 64'(resp_valid), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_load_phys();
    t_kinds();
    t_misalign();
    t_unimpl();
    t_prot();
    t_regions();
    t_meta();
    t_mmio_atomic();
    t_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule